// File: doc/BRIEF.md
# Interrupt Request Capture and Acknowledge Latch

This block captures requests from eight interrupt lines into a request vector and tracks which of them have been taken into service. Each line is either edge-sensitive or level-sensitive, chosen per line by an internal trigger-mode register that is written through a simple write strobe. An edge-sensitive line records a request when its input rises. A level-sensitive line's request bit follows its input.

A downstream priority resolver decides which line to serve and presents the result as an acknowledge strobe with a line number. On acknowledge the block either marks the line in service or, in automatic end-of-interrupt mode, leaves the in-service vector alone. When rotation on automatic end-of-interrupt is also enabled, it moves the rotation base to the line after the acknowledged one. The resolver reads the request vector, the in-service vector and the rotation base. Inputs are taken to be synchronous to the clock and are sampled once per cycle. All outputs are registered and change one cycle after the stimulus.

Top module: `irq_req_latch`

## Requirements
- R1: A synchronous active-low reset clears the request vector, the in-service vector and the rotation base to zero, and it sets every line to edge mode (trigger-mode bit 0).
- R2: A line whose trigger-mode bit is 1 is level-sensitive. Its request bit equals the line's input as sampled on the previous clock edge, whether it rises or falls.
- R3: A line whose trigger-mode bit is 0 is edge-sensitive. Its request bit is set when it is sampled high after being sampled low on the previous edge. A falling input leaves the bit set.
- R4: An edge-sensitive line held high after its request has been acknowledged does not set its request bit again until it has been sampled low.
- R5: An acknowledge with automatic end-of-interrupt off sets the in-service bit at position `ack_line` on the next cycle. In-service bits are never cleared except by reset.
- R6: An acknowledge with automatic end-of-interrupt on leaves the in-service vector unchanged. If rotation is also on, the rotation base becomes (`ack_line` + 1) mod 8, so line 7 wraps to 0.
- R7: The rotation base holds its value on every cycle that is not an acknowledge with both automatic end-of-interrupt and rotation on.
- R8: An acknowledge clears the request bit of an edge-sensitive line. It does not clear the request bit of a level-sensitive line.
- R9: If an edge-sensitive line rises in the same cycle that it is acknowledged, its request bit is set on the next cycle.
- R10: A trigger-mode write (`mode_we` high, one bit per line, 1 = level) takes effect for input sampling from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 8 | Raw interrupt lines, synchronous to clk |
| mode_we | input | 1 | Write strobe for the trigger-mode register |
| mode_wdata | input | 8 | New trigger modes, bit i = 1 makes line i level-sensitive |
| ack_valid | input | 1 | Acknowledge strobe, one cycle per acknowledge |
| ack_line | input | 3 | Number of the acknowledged line |
| auto_eoi | input | 1 | Automatic end-of-interrupt mode |
| rot_on_aeoi | input | 1 | Rotate the priority base on automatic end-of-interrupt |
| req_vec | output | 8 | Request vector |
| isr_vec | output | 8 | In-service vector |
| rot_base | output | 3 | Rotation base for the priority resolver |

## Verification
The hardest case to reach is an edge-sensitive line that rises in the same cycle it is acknowledged. This only happens when the input is low in one cycle and high in the next while the acknowledge for that very line is presented. The vector table builds this case on purpose: it first leaves line 1 low, then raises it together with its acknowledge. It then holds the line high through a second acknowledge to show that the re-armed request is cleared and does not come back. A trigger-mode change while a level request is pending is reached in a similar way. Line 7 is kept high as a level line, then switched to edge mode and dropped, so the request must survive the fall.

// File: rtl/irq_latch_pkg.sv
// Package: shared constants and helpers for the interrupt request latch.
// Assumes a power-of-two line count so that rotation wraps by width.
package irq_latch_pkg;

    localparam int unsigned DEF_LINES = 8;

    // Next line after 'line', wrapping at 'lines'.
    function automatic int unsigned next_line(input int unsigned line, input int unsigned lines);
        return (line + 1 >= lines) ? 0 : line + 1;
    endfunction

endpackage

// File: rtl/irq_mode_reg.sv
// Module: irq_mode_reg
// Holds the per-line trigger-mode register (1 = level, 0 = edge).
// Assumes: writes are single-cycle strobes; reset selects all-edge.
module irq_mode_reg #(
    parameter int unsigned NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [NUM_LINES-1:0] wr_data,
    output logic [NUM_LINES-1:0] level_mode
);

    logic [NUM_LINES-1:0] mode_r;

    // Load the mode register on a write; reset to all-edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_r <= '0;
        end else if (wr_en) begin
            mode_r <= wr_data;
        end
    end

    assign level_mode = mode_r;

endmodule

// File: rtl/irq_line_cell.sv
// Module: irq_line_cell
// Request capture for one interrupt line with edge or level sensing.
// Assumes: raw input synchronous to clk; ack_hit is high for one cycle
// when this line is acknowledged. In edge mode the acknowledge clear is
// applied before a same-cycle rising edge sets the bit again.
module irq_line_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    input  logic level_mode,
    input  logic ack_hit,
    output logic req
);

    logic prev_lvl;
    logic req_r;
    logic rise;
    logic req_nxt;

    assign rise = raw_in & ~prev_lvl;

    // Compute the next request bit for the selected trigger mode.
    always_comb begin
        if (level_mode) begin
            req_nxt = raw_in;
        end else begin
            req_nxt = (req_r & ~ack_hit) | rise;
        end
    end

    // Register the remembered level and the request bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_lvl <= 1'b0;
            req_r    <= 1'b0;
        end else begin
            prev_lvl <= raw_in;
            req_r    <= req_nxt;
        end
    end

    assign req = req_r;

endmodule

// File: rtl/irq_ack_ctrl.sv
// Module: irq_ack_ctrl
// Decodes the acknowledge, keeps the in-service vector and the rotation base.
// Assumes: ack_line is below NUM_LINES whenever ack_valid is high.
module irq_ack_ctrl #(
    parameter int unsigned NUM_LINES = 8,
    localparam int unsigned LINE_W   = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ack_valid,
    input  logic [LINE_W-1:0]    ack_line,
    input  logic                 auto_eoi,
    input  logic                 rot_on_aeoi,
    output logic [NUM_LINES-1:0] ack_hit,
    output logic [NUM_LINES-1:0] in_service,
    output logic [LINE_W-1:0]    rot_base
);

    logic [NUM_LINES-1:0] isr_r;
    logic [LINE_W-1:0]    rot_r;
    logic [LINE_W-1:0]    line_after;

    // One-hot decode of the acknowledged line.
    always_comb begin
        ack_hit = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (ack_valid && (ack_line == LINE_W'(i))) begin
                ack_hit[i] = 1'b1;
            end
        end
    end

    assign line_after = LINE_W'(irq_latch_pkg::next_line(32'(ack_line), NUM_LINES));

    // Mark the acknowledged line in service unless auto-EOI is on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_r <= '0;
        end else if (ack_valid && !auto_eoi) begin
            isr_r <= isr_r | ack_hit;
        end
    end

    // Move the rotation base on auto-EOI acknowledges with rotation enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rot_r <= '0;
        end else if (ack_valid && auto_eoi && rot_on_aeoi) begin
            rot_r <= line_after;
        end
    end

    assign in_service = isr_r;
    assign rot_base   = rot_r;

endmodule

// File: rtl/irq_req_latch.sv
// Module: irq_req_latch (top)
// Interrupt request latch with per-line edge/level trigger and acknowledge
// handling (in-service marking or automatic EOI with optional rotation).
// Assumes: all inputs synchronous to clk; priority resolution lies outside.
module irq_req_latch #(
    parameter int unsigned NUM_LINES = 8,
    localparam int unsigned LINE_W   = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 mode_we,
    input  logic [NUM_LINES-1:0] mode_wdata,
    input  logic                 ack_valid,
    input  logic [LINE_W-1:0]    ack_line,
    input  logic                 auto_eoi,
    input  logic                 rot_on_aeoi,
    output logic [NUM_LINES-1:0] req_vec,
    output logic [NUM_LINES-1:0] isr_vec,
    output logic [LINE_W-1:0]    rot_base
);

    logic [NUM_LINES-1:0] mode_q;
    logic [NUM_LINES-1:0] ack_hit;

    irq_mode_reg #(.NUM_LINES(NUM_LINES)) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (mode_we),
        .wr_data    (mode_wdata),
        .level_mode (mode_q)
    );

    irq_ack_ctrl #(.NUM_LINES(NUM_LINES)) u_ack (
        .clk         (clk),
        .rst_n       (rst_n),
        .ack_valid   (ack_valid),
        .ack_line    (ack_line),
        .auto_eoi    (auto_eoi),
        .rot_on_aeoi (rot_on_aeoi),
        .ack_hit     (ack_hit),
        .in_service  (isr_vec),
        .rot_base    (rot_base)
    );

    // One capture cell per interrupt line.
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        irq_line_cell u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .raw_in     (irq_in[g]),
            .level_mode (mode_q[g]),
            .ack_hit    (ack_hit[g]),
            .req        (req_vec[g])
        );
    end

endmodule

// File: rtl/irq_req_latch_chk.sv
// Module: irq_req_latch_chk
// Property checker bound to irq_req_latch.
module irq_req_latch_chk #(
    parameter int unsigned NUM_LINES = 8,
    localparam int unsigned LINE_W   = $clog2(NUM_LINES)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] irq_in,
    input logic [NUM_LINES-1:0] mode_q,
    input logic                 ack_valid,
    input logic [LINE_W-1:0]    ack_line,
    input logic                 auto_eoi,
    input logic                 rot_on_aeoi,
    input logic [NUM_LINES-1:0] req_vec,
    input logic [NUM_LINES-1:0] isr_vec,
    input logic [LINE_W-1:0]    rot_base
);

    logic [LINE_W-1:0] exp_rot;
    assign exp_rot = (ack_line == LINE_W'(NUM_LINES - 1)) ? '0 : ack_line + 1'b1;

    a_r5_ack_sets_isr: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !auto_eoi) |=> isr_vec[$past(ack_line)]);

    a_r5_isr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((isr_vec & $past(isr_vec)) == $past(isr_vec)));

    a_r6_aeoi_keeps_isr: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && auto_eoi) |=> $stable(isr_vec));

    a_r6_rotate: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && auto_eoi && rot_on_aeoi) |=> (rot_base == $past(exp_rot)));

    a_r7_rot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_valid && auto_eoi && rot_on_aeoi) |=> $stable(rot_base));

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_prop
        a_r2_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
            mode_q[g] |=> (req_vec[g] == $past(irq_in[g])));

        a_r3_fall_keeps_req: assert property (@(posedge clk) disable iff (!rst_n)
            (!mode_q[g] && req_vec[g] && !(ack_valid && ack_line == LINE_W'(g)))
            |=> req_vec[g]);
    end

endmodule

bind irq_req_latch irq_req_latch_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_in      (irq_in),
    .mode_q      (mode_q),
    .ack_valid   (ack_valid),
    .ack_line    (ack_line),
    .auto_eoi    (auto_eoi),
    .rot_on_aeoi (rot_on_aeoi),
    .req_vec     (req_vec),
    .isr_vec     (isr_vec),
    .rot_base    (rot_base)
);

// File: tb/test_irq_req_latch.sv
// Bench for irq_req_latch: table-driven sequence then directed reset tests.
module test_irq_req_latch;

    localparam int N = 8;
    localparam int LW = 3;
    // Row: tag(4) in(8) ack(1) line(3) aeoi(1) rot(1) mwe(1) mdat(8) ereq(8) eisr(8) erot(3)
    localparam int RW = 4 + 8 + 1 + 3 + 1 + 1 + 1 + 8 + 8 + 8 + 3;
    localparam int NV = 16;

    localparam logic [RW-1:0] TBL [NV] = '{
        // R3: line 0 rises (edge)
        {4'd3,  8'h01, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h01, 8'h00, 3'd0},
        // R3: falling input keeps request
        {4'd3,  8'h00, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h01, 8'h00, 3'd0},
        // R5/R8: ack line 0, sets isr, clears edge request
        {4'd5,  8'h00, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h01, 3'd0},
        // R10: write lines 4..7 as level
        {4'd10, 8'h00, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 8'hF0, 8'h00, 8'h01, 3'd0},
        // R2: level line 4 high
        {4'd2,  8'h10, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h10, 8'h01, 3'd0},
        // R8: ack level line 4, request stays
        {4'd8,  8'h10, 1'b1, 3'd4, 1'b0, 1'b0, 1'b0, 8'h00, 8'h10, 8'h11, 3'd0},
        // R2: level line 4 low clears
        {4'd2,  8'h00, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h11, 3'd0},
        // R9/R6: line 1 rises with its own auto-EOI ack + rotate
        {4'd9,  8'h02, 1'b1, 3'd1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h02, 8'h11, 3'd2},
        // R6: ack line 7 auto-EOI rotate wraps to 0
        {4'd6,  8'h02, 1'b1, 3'd7, 1'b1, 1'b1, 1'b0, 8'h00, 8'h02, 8'h11, 3'd0},
        // R7: ack line 1 auto-EOI no rotate
        {4'd7,  8'h02, 1'b1, 3'd1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 8'h11, 3'd0},
        // R4: line 1 held high does not re-set
        {4'd4,  8'h02, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h11, 3'd0},
        // R6: ack line 3 rotate -> 4; level line 7 high
        {4'd6,  8'h82, 1'b1, 3'd3, 1'b1, 1'b1, 1'b0, 8'h00, 8'h80, 8'h11, 3'd4},
        // R7: auto-EOI without rotate keeps base
        {4'd7,  8'h80, 1'b1, 3'd5, 1'b1, 1'b0, 1'b0, 8'h00, 8'h80, 8'h11, 3'd4},
        // R10: back to all-edge; this cycle still level
        {4'd10, 8'h80, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h80, 8'h11, 3'd4},
        // R10: line 7 now edge, fall keeps request
        {4'd10, 8'h00, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h80, 8'h11, 3'd4},
        // R5: ack line 7, isr set, request cleared
        {4'd5,  8'h00, 1'b1, 3'd7, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h91, 3'd4}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_in = '0;
    logic          mode_we = 1'b0;
    logic [N-1:0]  mode_wdata = '0;
    logic          ack_valid = 1'b0;
    logic [LW-1:0] ack_line = '0;
    logic          auto_eoi = 1'b0;
    logic          rot_on_aeoi = 1'b0;
    logic [N-1:0]  req_vec;
    logic [N-1:0]  isr_vec;
    logic [LW-1:0] rot_base;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_req_latch i_irq_req_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_in      (irq_in),
        .mode_we     (mode_we),
        .mode_wdata  (mode_wdata),
        .ack_valid   (ack_valid),
        .ack_line    (ack_line),
        .auto_eoi    (auto_eoi),
        .rot_on_aeoi (rot_on_aeoi),
        .req_vec     (req_vec),
        .isr_vec     (isr_vec),
        .rot_base    (rot_base)
    );

    task automatic check(input int tag, input logic [N-1:0] ereq,
                         input logic [N-1:0] eisr, input logic [LW-1:0] erot);
        checks++;
        if (req_vec !== ereq || isr_vec !== eisr || rot_base !== erot) begin
            errors++;
            $display("FAIL R%0d: req=%h isr=%h rot=%0d expected req=%h isr=%h rot=%0d",
                     tag, req_vec, isr_vec, rot_base, ereq, eisr, erot);
        end
    endtask

    task automatic idle();
        irq_in = '0; mode_we = 1'b0; mode_wdata = '0;
        ack_valid = 1'b0; ack_line = '0; auto_eoi = 1'b0; rot_on_aeoi = 1'b0;
    endtask

    // Apply inputs after a falling edge, sample after the next one.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        idle();
        repeat (3) @(negedge clk);
        check(1, 8'h00, 8'h00, 3'd0);  // R1 reset state
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            logic [RW-1:0] r;
            r = TBL[k];
            irq_in      = r[RW-5 -: 8];
            ack_valid   = r[RW-13];
            ack_line    = r[RW-14 -: 3];
            auto_eoi    = r[RW-17];
            rot_on_aeoi = r[RW-18];
            mode_we     = r[RW-19];
            mode_wdata  = r[RW-20 -: 8];
            step();
            check(int'(r[RW-1 -: 4]), r[18:11], r[10:3], r[2:0]);
        end

        // R1: mid-run reset clears state; set all-level first
        idle();
        mode_we = 1'b1; mode_wdata = 8'hFF;
        step();
        idle();
        irq_in = 8'h01;
        rst_n = 1'b0;
        step();
        check(1, 8'h00, 8'h00, 3'd0);
        rst_n = 1'b1;
        step();
        check(1, 8'h01, 8'h00, 3'd0);       // R1 edge capture of held line
        ack_valid = 1'b1; ack_line = 3'd0;
        step();
        ack_valid = 1'b0;
        check(1, 8'h00, 8'h01, 3'd0);       // R1: edge mode, ack cleared request
        step();
        check(1, 8'h00, 8'h01, 3'd0);       // R1/R4: held high, no re-set
        irq_in = 8'h00;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule